// File: doc/BRIEF.md
# Dual-Port Synthesizer Configuration Register

This block holds the active loop modulus, output-divider select and test code of a clock synthesizer. Two sources can set them. A parallel port presents a 9-bit modulus and a 2-bit divider select. A three-wire serial port fills a 14-bit shift register. That register carries a 3-bit test code, then the divider select, then the modulus, each field sent most significant bit first. Two load lines of opposite polarity decide which source the held configuration follows. The active-low parallel load line follows the parallel inputs and captures on its rising edge. The active-high serial load line follows the shift register and captures on its falling edge. The parallel source always wins.

All port signals are sampled on the block clock. The serial clock is edge-detected in that domain, so it must run well below the block clock. The "transparent latches" are registers that track their source for as long as their control level is active. A three-state machine selects their source. LAT_PARALLEL is entered whenever the parallel load line is low. LAT_SERIAL is entered when the parallel line is high and the serial load line is high. LAT_HOLD is entered when the parallel line is high and the serial line is low. Every state can move directly to either of the other two. The transitions are PARALLEL→SERIAL, PARALLEL→HOLD, SERIAL→PARALLEL, SERIAL→HOLD, HOLD→PARALLEL and HOLD→SERIAL. While in LAT_PARALLEL the test code is forced to zero. The first bit shifted (the oldest bit in the register) is brought out for observation.

Top module: `cfgsyn_regs`

## Requirements
- R1: After reset the modulus output reads 511, the divider select reads 3, the test code reads 0, the division factor reads 16 and the observation bit reads 0.
- R2: The shift register takes the serial data value on each rising edge of the serial clock. A falling serial clock edge, or a data change while the serial clock is static, leaves the register unchanged.
- R3: A 14-bit serial word is interpreted as test code in bits 13..11 (sent first), divider select in bits 10..9 and modulus in bits 8..0 (sent last), each field MSB first.
- R4: With the parallel load line high and the serial load line high, the outputs follow the shift register. A configuration sampled on one clock edge is visible after the third following edge.
- R5: With the parallel load line high and the serial load line low, the outputs hold, whatever is shifted in. The value kept is the one present when the serial load line fell.
- R6: With the parallel load line low, the modulus and divider-select outputs follow the parallel inputs. They keep the values that were present while the line was low when it rises.
- R7: When both load lines are active together, the parallel inputs drive the configuration. A word shifted in before the parallel line rises is not applied unless the serial load line is asserted again.
- R8: The test code output is 000 whenever the configuration follows the parallel port.
- R9: The division factor output equals 2, 4, 8 or 16 for divider select 00, 01, 10 or 11.
- R10: The observation output is the shift-register bit that was shifted in 14 rising serial clock edges earlier (bit 13).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; shifts on its rising edge |
| sdata_i | input | 1 | Serial data |
| sload_i | input | 1 | Serial load line, high = follow shift register |
| pload_n_i | input | 1 | Parallel load line, low = follow parallel inputs |
| m_par_i | input | 9 | Parallel modulus |
| n_par_i | input | 2 | Parallel divider select |
| m_o | output | 9 | Active modulus |
| n_o | output | 2 | Active divider select |
| t_o | output | 3 | Active test code |
| div_o | output | 5 | Output division factor decoded from n_o |
| sr_last_o | output | 1 | Oldest shift-register bit |

## Verification
Two functions can fall in the same cycle: the parallel load and a pending serial load. Both load lines go active on one clock edge, after a word with a nonzero test code has been shifted in but not yet loaded. The outputs must show the parallel modulus and select with a zero test code. After the serial line drops and then the parallel line rises, the shifted word must still be absent. The bench also moves the parallel line and the parallel data on one edge, and expects the value captured before that edge to be kept.

// File: rtl/cfgsyn_pkg.sv
package cfgsyn_pkg;

    typedef enum logic [1:0] {
        LAT_HOLD     = 2'd0,
        LAT_SERIAL   = 2'd1,
        LAT_PARALLEL = 2'd2
    } lat_mode_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic sload;
        logic pload_n;
    } ctl_t;

endpackage

// File: rtl/cfgsyn_sample.sv
module cfgsyn_sample
    import cfgsyn_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  ctl_t ctl_i,
    output ctl_t ctl_o,
    output logic shift_o
);
    ctl_t ctl_q;
    logic sclk_prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q       <= '{sclk: 1'b0, sdata: 1'b0, sload: 1'b0, pload_n: 1'b1};
            sclk_prev_q <= 1'b0;
        end else begin
            ctl_q       <= ctl_i;
            sclk_prev_q <= ctl_q.sclk;
        end
    end

    assign ctl_o   = ctl_q;
    assign shift_o = ctl_q.sclk & ~sclk_prev_q;
endmodule

// File: rtl/cfgsyn_shift.sv
module cfgsyn_shift #(
    parameter int SR_W = 14
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    input  logic            bit_i,
    output logic [SR_W-1:0] sr_o
);
    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)     sr_q <= '0;
        else if (en_i) sr_q <= {sr_q[SR_W-2:0], bit_i};
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/cfgsyn_latch.sv
module cfgsyn_latch
    import cfgsyn_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    localparam int SR_W = M_W + N_W + T_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            pload_n_i,
    input  logic            sload_i,
    input  logic [M_W-1:0]  m_par_i,
    input  logic [N_W-1:0]  n_par_i,
    input  logic [SR_W-1:0] sr_i,
    output logic [M_W-1:0]  m_o,
    output logic [N_W-1:0]  n_o,
    output logic [T_W-1:0]  t_o
);
    localparam int N_LO = M_W;
    localparam int T_LO = M_W + N_W;

    lat_mode_e      state_q, state_d;
    logic [M_W-1:0] m_p1_q, m_p2_q;
    logic [N_W-1:0] n_p1_q, n_p2_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_PARALLEL: begin
                if (pload_n_i) state_d = sload_i ? LAT_SERIAL : LAT_HOLD;
            end
            LAT_SERIAL: begin
                if (!pload_n_i)   state_d = LAT_PARALLEL;
                else if (!sload_i) state_d = LAT_HOLD;
            end
            LAT_HOLD: begin
                if (!pload_n_i)   state_d = LAT_PARALLEL;
                else if (sload_i) state_d = LAT_SERIAL;
            end
            default: state_d = LAT_HOLD;
        endcase
    end

    // state register and parallel data alignment stages
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LAT_HOLD;
            m_p1_q  <= '1;
            m_p2_q  <= '1;
            n_p1_q  <= '1;
            n_p2_q  <= '1;
        end else begin
            state_q <= state_d;
            m_p1_q  <= m_par_i;
            m_p2_q  <= m_p1_q;
            n_p1_q  <= n_par_i;
            n_p2_q  <= n_p1_q;
        end
    end

    // configuration holding registers, source picked by the state
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            m_o <= '1;
            n_o <= '1;
            t_o <= '0;
        end else begin
            unique case (state_q)
                LAT_PARALLEL: begin
                    m_o <= m_p2_q;
                    n_o <= n_p2_q;
                    t_o <= '0;
                end
                LAT_SERIAL: begin
                    m_o <= sr_i[M_W-1:0];
                    n_o <= sr_i[N_LO +: N_W];
                    t_o <= sr_i[T_LO +: T_W];
                end
                LAT_HOLD: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfgsyn_regs.sv
module cfgsyn_regs
    import cfgsyn_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    localparam int SR_W  = M_W + N_W + T_W,
    localparam int DIV_W = (1 << N_W) + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             sload_i,
    input  logic             pload_n_i,
    input  logic [M_W-1:0]   m_par_i,
    input  logic [N_W-1:0]   n_par_i,
    output logic [M_W-1:0]   m_o,
    output logic [N_W-1:0]   n_o,
    output logic [T_W-1:0]   t_o,
    output logic [DIV_W-1:0] div_o,
    output logic             sr_last_o
);
    ctl_t            ctl_in, ctl_q;
    logic            shift_en;
    logic [SR_W-1:0] sr_q;

    assign ctl_in = '{sclk: sclk_i, sdata: sdata_i, sload: sload_i, pload_n: pload_n_i};

    cfgsyn_sample u_sample (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ctl_i   (ctl_in),
        .ctl_o   (ctl_q),
        .shift_o (shift_en)
    );

    cfgsyn_shift #(.SR_W(SR_W)) u_shift (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (shift_en),
        .bit_i (ctl_q.sdata),
        .sr_o  (sr_q)
    );

    cfgsyn_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pload_n_i (ctl_q.pload_n),
        .sload_i   (ctl_q.sload),
        .m_par_i   (m_par_i),
        .n_par_i   (n_par_i),
        .sr_i      (sr_q),
        .m_o       (m_o),
        .n_o       (n_o),
        .t_o       (t_o)
    );

    assign div_o     = DIV_W'(2) << n_o;
    assign sr_last_o = sr_q[SR_W-1];
endmodule

// File: rtl/cfgsyn_chk.sv
module cfgsyn_chk #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    localparam int SR_W  = M_W + N_W + T_W,
    localparam int DIV_W = (1 << N_W) + 1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sclk_i,
    input logic             sdata_i,
    input logic             sload_i,
    input logic             pload_n_i,
    input logic [M_W-1:0]   m_par_i,
    input logic [N_W-1:0]   n_par_i,
    input logic [M_W-1:0]   m_o,
    input logic [N_W-1:0]   n_o,
    input logic [T_W-1:0]   t_o,
    input logic [DIV_W-1:0] div_o,
    input logic [SR_W-1:0]  sr_q
);
    logic [2:0] age_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    // R2
    shift_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 3'd4 && $past(sclk_i, 2) && !$past(sclk_i, 3))
        |-> sr_q[0] == $past(sdata_i, 2));

    // R4
    ser_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 3'd4 && $past(pload_n_i, 3) && $past(sload_i, 3))
        |-> {t_o, n_o, m_o} == $past(sr_q));

    // R5
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 3'd4 && $past(pload_n_i, 3) && !$past(sload_i, 3))
        |-> ($stable(m_o) && $stable(n_o) && $stable(t_o)));

    // R6 R7 R8
    par_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 3'd4 && !$past(pload_n_i, 3))
        |-> (m_o == $past(m_par_i, 3) && n_o == $past(n_par_i, 3) && t_o == '0));

    // R9
    div_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(div_o) && !div_o[0]);
endmodule

bind cfgsyn_regs cfgsyn_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sclk_i    (sclk_i),
    .sdata_i   (sdata_i),
    .sload_i   (sload_i),
    .pload_n_i (pload_n_i),
    .m_par_i   (m_par_i),
    .n_par_i   (n_par_i),
    .m_o       (m_o),
    .n_o       (n_o),
    .t_o       (t_o),
    .div_o     (div_o),
    .sr_q      (sr_q)
);

// File: tb/cfgsyn_regs_test.sv
`timescale 1ns/1ps
module cfgsyn_regs_test;
    localparam int M_W = 9, N_W = 2, T_W = 3;
    localparam int SR_W = M_W + N_W + T_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst, sclk, sdata, sload, pload_n;
    logic [M_W-1:0] m_par, m_out;
    logic [N_W-1:0] n_par, n_out;
    logic [T_W-1:0] t_out;
    logic [4:0]     div_out;
    logic           sr_last;

    cfgsyn_regs uut (
        .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .sdata_i(sdata),
        .sload_i(sload), .pload_n_i(pload_n), .m_par_i(m_par), .n_par_i(n_par),
        .m_o(m_out), .n_o(n_out), .t_o(t_out), .div_o(div_out), .sr_last_o(sr_last)
    );

    int n_run = 0, n_fail = 0;
    logic [SR_W-1:0] sr_m = '0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        sdata = b; sclk = 1'b0; tick(2);
        sclk = 1'b1; tick(2);
        sr_m = {sr_m[SR_W-2:0], b};
    endtask

    task automatic shift_word(logic [SR_W-1:0] w);
        for (int i = SR_W - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic check_cfg(string req, logic [SR_W-1:0] exp);
        check(req, 32'({t_out, n_out, m_out}), 32'(exp));
    endtask

    initial begin
        logic [SR_W-1:0] w, held;
        rst = 1'b1; sclk = 1'b0; sdata = 1'b0; sload = 1'b0; pload_n = 1'b1;
        m_par = '1; n_par = '1;
        tick(3); rst = 1'b0; tick(1);

        // R1 reset state
        check("R1 modulus", 32'(m_out), 511);
        check("R1 select", 32'(n_out), 3);
        check("R1 test code", 32'(t_out), 0);
        check("R1 factor", 32'(div_out), 16);
        check("R1 observe", 32'(sr_last), 0);

        // R6 R8 R9 exhaustive parallel sweep
        pload_n = 1'b0;
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 512; m++) begin
                m_par = M_W'(m); n_par = N_W'(n);
                tick(4);
                check("R6 modulus", 32'(m_out), m);
                check("R6 select", 32'(n_out), n);
                check("R8 test code", 32'(t_out), 0);
                check("R9 factor", 32'(div_out), 32'(2) << n);
            end
        end

        // R6 capture on rising parallel line, data changing on the same edge
        m_par = 9'h0A5; n_par = 2'd2; tick(4);
        pload_n = 1'b1; m_par = 9'h15A; n_par = 2'd1; tick(5);
        check_cfg("R6 capture", {3'd0, 2'd2, 9'h0A5});
        held = {3'd0, 2'd2, 9'h0A5};

        // R3 R5 R10 serial words loaded by pulses
        for (int t = 0; t < 8; t++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 8; k++) begin
                    w = {T_W'(t), N_W'(n), M_W'((k * 73 + t * 37 + n * 11) % 512)};
                    shift_word(w);
                    tick(3);
                    check("R10 observe", 32'(sr_last), 32'(w[SR_W-1]));
                    check_cfg("R5 hold while shifting", held);
                    sload = 1'b1; tick(4); sload = 1'b0; tick(3);
                    check("R3 test field", 32'(t_out), t);
                    check("R3 select field", 32'(n_out), n);
                    check("R3 modulus field", 32'(m_out), 32'(w[M_W-1:0]));
                    check("R9 factor", 32'(div_out), 32'(2) << n);
                    held = w;
                end
            end
        end

        // R2 falling edge and static-clock data changes do not shift
        w = 14'b011_10_101100110;
        shift_word(w);
        sdata = ~sdata; tick(2);
        sclk = 1'b0; tick(2);
        for (int i = 0; i < 6; i++) begin sdata = ~sdata; tick(2); end
        sload = 1'b1; tick(4); sload = 1'b0; tick(3);
        check_cfg("R2 no extra shift", w);
        check("R2 observe", 32'(sr_last), 32'(w[SR_W-1]));

        // R4 transparent serial path follows each shifted bit
        sload = 1'b1;
        for (int i = 0; i < SR_W; i++) begin
            shift_bit(logic'((i * 5 + 1) % 3 == 0));
            tick(2);
            check_cfg("R4 follow", sr_m);
        end
        sload = 1'b0; tick(3);
        held = sr_m;
        shift_word(14'h1555);
        tick(3);
        check_cfg("R5 hold after fall", held);

        // R7 parallel wins over a pending serial word
        shift_word(14'b101_11_000011110);
        tick(2);
        pload_n = 1'b0; sload = 1'b1; m_par = 9'h033; n_par = 2'd0;
        tick(5);
        check_cfg("R7 both active", {3'd0, 2'd0, 9'h033});
        check("R9 factor", 32'(div_out), 2);
        sload = 1'b0; tick(2);
        pload_n = 1'b1; tick(5);
        check_cfg("R7 pending word ignored", {3'd0, 2'd0, 9'h033});
        sload = 1'b1; tick(4); sload = 1'b0; tick(3);
        check_cfg("R4 reload after priority", 14'b101_11_000011110);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule